// File: doc/BRIEF.md
# Two-channel PIO command controller

This block carries out the device-level commands that follow a completed addressing phase on a single-wire slave. The bit-level engine sits in front of it and exchanges whole bytes through a small handshake. A one-cycle strobe tells the block that the command phase has begun. A second strobe marks the most significant bit of whichever byte is on the wire at that moment. A third input reports a bus reset pulse. The block owns one output latch per channel, and each latch drives an open-drain pulldown enable. It also samples the level of each channel's pin.

There are two commands. A status-read command sends back a self-checking status byte without end. A guarded-write command accepts a data byte followed by its bitwise inverse. It changes the latches only when the two bytes agree. It confirms with a fixed pattern, returns fresh status, and then waits for the next data byte. Only a bus reset ends either loop.

The engine must raise `ms_bit_i` at least one cycle before the `rx_valid_i` or `tx_done_i` pulse of the same byte.

Top module: `pio_cmd_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, both latches are 1 (`pd_en_o` = 00) and `tx_valid_o` is low.
- R2: The command byte F5h, received after `cmd_start_i`, starts the read loop. Every byte sent is a status byte: bit0 is the channel A pin, bit1 the channel A latch, bit2 the channel B pin, bit3 the channel B latch.
- R3: In every status byte, bits 7:4 equal the bitwise inverse of bits 3:0. Any byte on `tx_byte_o` while `tx_valid_o` is high is a status byte, AAh or FFh.
- R4: Pins and latches of both channels are captured together on each `ms_bit_i` cycle. A status byte reflects the capture made during the last bit of the byte before it, which is the command byte or the previous status byte. Pin changes after that capture do not alter it.
- R5: The command byte 5Ah starts the write loop. Data bit0 controls channel A and bit1 controls channel B, and a 0 turns the pulldown on. The latches take the data only if the next received byte is its exact bitwise inverse. They change on the cycle after that inverted byte arrives, and never at any other time.
- R6: After a valid pair, the block sends AAh, then a status byte captured during the AAh's last bit. It then lowers `tx_valid_o` and waits for the next data byte.
- R7: If the inverted copy does not match, the latches keep their value and every following byte sent is FFh until a bus reset.
- R8: `bus_rst_i` ends any loop, and `tx_valid_o` is low on the following cycle. It takes priority over a byte received in the same cycle, and it never changes the latches.
- R9: An unrecognised command code puts the block in a silent wait. So does any byte received before `cmd_start_i`. Neither sends any byte, and neither changes the latches until the next bus reset and command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | Bus reset pulse seen on the line |
| cmd_start_i | input | 1 | Addressing done, next byte is a command |
| rx_valid_i | input | 1 | One-cycle pulse: a byte from the master is complete |
| rx_byte_i | input | 8 | Byte received from the master |
| ms_bit_i | input | 1 | Most significant bit of the current byte is on the wire |
| tx_done_i | input | 1 | One-cycle pulse: the offered byte has been sent |
| tx_valid_o | output | 1 | A byte is offered to the engine |
| tx_byte_o | output | 8 | Byte offered to the engine |
| pin_i | input | 2 | Pin levels, bit0 channel A, bit1 channel B |
| pd_en_o | output | 2 | Pulldown enables, 1 = transistor on |

## Verification
Two events can fall in the same clock cycle. One is a bus reset. The other is the arrival of the inverted byte that would otherwise commit a latch update. The bench provokes this on purpose by raising `bus_rst_i` together with `rx_valid_i` on a correctly inverted byte. It then judges the outcome by checking that `pd_en_o` is unchanged and `tx_valid_o` is low. A second case is a pin change right after the capture strobe. The bench drives new random pin values on the cycle after every `ms_bit_i` and expects the earlier levels in the next status byte.

// File: rtl/pio_cmd_pkg.sv
package pio_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = 2;
  localparam int ST_W   = 2 * NUM_CH;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OP_STATUS = 8'hF5;
  localparam byte_t OP_GUARD  = 8'h5A;
  localparam byte_t PAT_OK    = 8'hAA;
  localparam byte_t PAT_BAD   = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_STREAM,
    ST_DATA,
    ST_INVERSE,
    ST_CONFIRM,
    ST_REPORT,
    ST_REJECT,
    ST_PARKED
  } ctl_state_e;

  // status byte: capture in the low half, its inverse in the high half
  function automatic byte_t pack_status(input logic [ST_W-1:0] cap);
    return {~cap, cap};
  endfunction
endpackage

// File: rtl/pio_sampler.sv
module pio_sampler
  import pio_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe,
  input  logic [NUM_CH-1:0]     pin,
  input  logic [NUM_CH-1:0]     latch,
  output logic [ST_W-1:0]       cap
);
  // each channel contributes {latch, pin}, all captured on the same edge
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0] pair_q;
    always_ff @(posedge clk) begin
      if (rst)
        pair_q <= 2'b11;
      else if (strobe)
        pair_q <= {latch[c], pin[c]};
    end
    assign cap[2*c +: 2] = pair_q;
  end
endmodule

// File: rtl/pio_latch_bank.sv
module pio_latch_bank
  import pio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NUM_CH-1:0] value,
  output logic [NUM_CH-1:0] latch
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lat
    logic lat_q;
    always_ff @(posedge clk) begin
      if (rst)
        lat_q <= 1'b1;
      else if (load)
        lat_q <= value[c];
    end
    assign latch[c] = lat_q;
  end
endmodule

// File: rtl/pio_cmd_fsm.sv
module pio_cmd_fsm
  import pio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              cmd_start,
  input  logic              rx_valid,
  input  byte_t             rx_byte,
  input  logic              tx_done,
  input  logic [ST_W-1:0]   cap,
  output logic              tx_valid,
  output byte_t             tx_byte,
  output logic              lat_load,
  output logic [NUM_CH-1:0] lat_value
);
  ctl_state_e state_q;
  byte_t      data_q;
  logic       pair_ok;

  assign pair_ok   = (rx_byte == ~data_q);
  assign lat_load  = (state_q == ST_INVERSE) && rx_valid && !bus_rst && pair_ok;
  assign lat_value = data_q[NUM_CH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tx_valid <= 1'b0;
      tx_byte  <= PAT_BAD;
      data_q   <= '1;
    end else if (bus_rst) begin
      state_q  <= ST_IDLE;
      tx_valid <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_start) state_q <= ST_OPCODE;
        end
        ST_OPCODE: begin
          if (rx_valid) begin
            if (rx_byte == OP_STATUS) begin
              state_q  <= ST_STREAM;
              tx_valid <= 1'b1;
              tx_byte  <= pack_status(cap);
            end else if (rx_byte == OP_GUARD) begin
              state_q  <= ST_DATA;
            end else begin
              state_q  <= ST_PARKED;
            end
          end
        end
        ST_STREAM: begin
          if (tx_done) tx_byte <= pack_status(cap);
        end
        ST_DATA: begin
          if (rx_valid) begin
            data_q  <= rx_byte;
            state_q <= ST_INVERSE;
          end
        end
        ST_INVERSE: begin
          if (rx_valid) begin
            tx_valid <= 1'b1;
            if (pair_ok) begin
              state_q <= ST_CONFIRM;
              tx_byte <= PAT_OK;
            end else begin
              state_q <= ST_REJECT;
              tx_byte <= PAT_BAD;
            end
          end
        end
        ST_CONFIRM: begin
          if (tx_done) begin
            state_q <= ST_REPORT;
            tx_byte <= pack_status(cap);
          end
        end
        ST_REPORT: begin
          if (tx_done) begin
            state_q  <= ST_DATA;
            tx_valid <= 1'b0;
          end
        end
        ST_REJECT: begin
          tx_byte <= PAT_BAD;
        end
        ST_PARKED: begin
          tx_valid <= 1'b0;
        end
        default: begin
          state_q  <= ST_IDLE;
          tx_valid <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pio_cmd_ctrl.sv
module pio_cmd_ctrl
  import pio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_i,
  input  logic              cmd_start_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              ms_bit_i,
  input  logic              tx_done_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] pd_en_o
);
  logic [NUM_CH-1:0] latch;
  logic [ST_W-1:0]   cap;
  logic              lat_load;
  logic [NUM_CH-1:0] lat_value;

  pio_sampler i_sampler (
    .clk    (clk),
    .rst    (rst),
    .strobe (ms_bit_i),
    .pin    (pin_i),
    .latch  (latch),
    .cap    (cap)
  );

  pio_latch_bank i_latches (
    .clk   (clk),
    .rst   (rst),
    .load  (lat_load),
    .value (lat_value),
    .latch (latch)
  );

  pio_cmd_fsm i_fsm (
    .clk       (clk),
    .rst       (rst),
    .bus_rst   (bus_rst_i),
    .cmd_start (cmd_start_i),
    .rx_valid  (rx_valid_i),
    .rx_byte   (rx_byte_i),
    .tx_done   (tx_done_i),
    .cap       (cap),
    .tx_valid  (tx_valid_o),
    .tx_byte   (tx_byte_o),
    .lat_load  (lat_load),
    .lat_value (lat_value)
  );

  // latch value 0 means the pulldown conducts
  assign pd_en_o = ~latch;
endmodule

// File: rtl/pio_cmd_ctrl_chk.sv
module pio_cmd_ctrl_chk
  import pio_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_rst_i,
  input logic              rx_valid_i,
  input logic              tx_valid_o,
  input logic [BYTE_W-1:0] tx_byte_o,
  input logic [NUM_CH-1:0] pd_en_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pd_en_o == '0 && !tx_valid_o));

  a_r3_byte_forms: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> (tx_byte_o == PAT_OK || tx_byte_o == PAT_BAD ||
                    tx_byte_o[7:4] == ~tx_byte_o[3:0]));

  a_r5_latch_needs_byte: assert property (@(posedge clk) disable iff (rst)
    !$stable(pd_en_o) |-> $past(rx_valid_i));

  a_r7_reject_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && tx_byte_o == PAT_BAD && !bus_rst_i) |=>
      (tx_valid_o && tx_byte_o == PAT_BAD));

  a_r8_bus_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> !tx_valid_o);

  a_r8_bus_reset_keeps_latch: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> $stable(pd_en_o));
endmodule

bind pio_cmd_ctrl pio_cmd_ctrl_chk i_chk (.*);

// File: tb/test_pio_cmd_ctrl.sv
module test_pio_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst_i = 1'b0;
  logic       cmd_start_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       ms_bit_i = 1'b0;
  logic       tx_done_i = 1'b0;
  logic       tx_valid_o;
  logic [7:0] tx_byte_o;
  logic [1:0] pin_i = 2'b11;
  logic [1:0] pd_en_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic done = 1'b0;

  logic [1:0] lat_m = 2'b11;
  logic [3:0] snap_m = 4'hF;

  pio_cmd_ctrl i_pio_cmd_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] exp_stat(input logic [3:0] s);
    return {~s, s};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe_ms(input logic [1:0] pins);
    pin_i = pins; ms_bit_i = 1'b1;
    @(negedge clk);
    snap_m = {lat_m[1], pins[1], lat_m[0], pins[0]};
    ms_bit_i = 1'b0; pin_i = 2'($urandom);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic [1:0] pins);
    strobe_ms(pins);
    rx_byte_i = b; rx_valid_i = 1'b1;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic get_byte(input logic [1:0] pins, input logic [7:0] exp, input string req);
    check(req, {7'b0, tx_valid_o}, 8'h01);
    check(req, tx_byte_o, exp);
    strobe_ms(pins);
    tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
  endtask

  task automatic bus_reset();
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
    check("R8 loop ends", {7'b0, tx_valid_o}, 8'h00);
    check("R8 latches kept", {6'b0, pd_en_o}, {6'b0, ~lat_m});
  endtask

  task automatic start_cmd();
    cmd_start_i = 1'b1;
    @(negedge clk);
    cmd_start_i = 1'b0;
  endtask

  task automatic write_pair(input logic [7:0] d, input logic [7:0] inv);
    put_byte(d, 2'($urandom));
    put_byte(inv, 2'($urandom));
    if (inv == ~d) begin
      lat_m = d[1:0];
      check("R5 latch update", {6'b0, pd_en_o}, {6'b0, ~lat_m});
      get_byte(2'($urandom), 8'hAA, "R6 confirm");
      get_byte(2'($urandom), exp_stat(snap_m), "R6 status after confirm");
      check("R6 waits for data", {7'b0, tx_valid_o}, 8'h00);
    end else begin
      check("R7 latches unchanged", {6'b0, pd_en_o}, {6'b0, ~lat_m});
      for (int k = 0; k < 3; k++) get_byte(2'($urandom), 8'hFF, "R7 reject bytes");
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check("R1 reset pulldowns off", {6'b0, pd_en_o}, 8'h00);
    check("R1 reset no tx", {7'b0, tx_valid_o}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {6'b0, pd_en_o}, 8'h00);

    // R9: bytes before the command phase are ignored
    put_byte(8'h5A, 2'b00);
    put_byte(8'hFC, 2'b00);
    put_byte(8'h03, 2'b00);
    check("R9 idle no tx", {7'b0, tx_valid_o}, 8'h00);
    check("R9 idle latches", {6'b0, pd_en_o}, 8'h00);

    // R2 R3 R4: read loop with random pins, changed after every strobe
    start_cmd();
    put_byte(8'hF5, 2'($urandom));
    for (int i = 0; i < 8; i++)
      get_byte(2'($urandom), exp_stat(snap_m), "R2 R3 R4 status");
    bus_reset();

    // R5 R6: documented example, both pulldowns on, pins pulled low
    start_cmd();
    put_byte(8'h5A, 2'b11);
    put_byte(8'hFC, 2'b01);
    put_byte(8'h03, 2'b10);
    lat_m = 2'b00;
    check("R5 example pulldowns", {6'b0, pd_en_o}, 8'h03);
    get_byte(2'b00, 8'hAA, "R6 example confirm");
    get_byte(2'b00, 8'hF0, "R6 example status");
    // loop continues: next pair switches channel A off only
    write_pair(8'hFD, 8'h02);
    bus_reset();

    // random writes mixed with corrupted copies
    for (int t = 0; t < 20; t++) begin
      logic [7:0] d;
      logic [7:0] inv;
      d = 8'($urandom);
      inv = ($urandom % 4 == 0) ? (~d ^ (8'h01 << ($urandom % 8))) : ~d;
      start_cmd();
      put_byte(8'h5A, 2'($urandom));
      write_pair(d, inv);
      if (inv == ~d) write_pair(8'($urandom) | 8'hFC, 8'h00);
      bus_reset();
    end

    // R8: bus reset in the same cycle as a correctly inverted byte
    start_cmd();
    put_byte(8'h5A, 2'b11);
    put_byte({6'h3F, lat_m ^ 2'b11}, 2'b11);
    strobe_ms(2'b11);
    rx_byte_i = ~{6'h3F, lat_m ^ 2'b11}; rx_valid_i = 1'b1; bus_rst_i = 1'b1;
    @(negedge clk);
    rx_valid_i = 1'b0; bus_rst_i = 1'b0;
    check("R8 priority latches", {6'b0, pd_en_o}, {6'b0, ~lat_m});
    check("R8 priority no tx", {7'b0, tx_valid_o}, 8'h00);

    // R9: unknown command parks the block
    start_cmd();
    put_byte(8'h33, 2'b00);
    put_byte(8'h5A, 2'b00);
    put_byte({6'h3F, ~lat_m}, 2'b00);
    put_byte({6'h00, lat_m}, 2'b00);
    check("R9 unknown no tx", {7'b0, tx_valid_o}, 8'h00);
    check("R9 unknown latches", {6'b0, pd_en_o}, {6'b0, ~lat_m});
    bus_reset();

    // R1: reset in the middle of a loop
    start_cmd();
    put_byte(8'h5A, 2'b00);
    write_pair(8'hFC, 8'h03);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid reset pulldowns", {6'b0, pd_en_o}, 8'h00);
    check("R1 mid reset no tx", {7'b0, tx_valid_o}, 8'h00);
    rst = 1'b0;
    lat_m = 2'b11;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule